// File: doc/BRIEF.md
# Belt Operand Store with Call Frames

This block holds operands without register names. Every result is dropped onto the front of a belt. A consumer names an operand by how many newer entries stand in front of it. Position 0 is the newest entry. When the belt is full, the next drop takes the place of the oldest entry. Up to two results can be dropped in one cycle, for example a quotient and a remainder. Two read ports look up positions combinationally.

No data moves when a result arrives. The storage is a circular array, and a head pointer walks around it. Each slot carries the frame number current at its drop. A call raises the frame number, so the callee sees an empty belt while the caller's slots stay where they are. A return lowers the frame number again. The caller's entries then reappear, and results dropped in the return cycle sit on top of them. A position counts only the slots of the current frame.

A small controller tracks the call depth in three states:
- `ST_TOP`: frame 0, no outstanding call.
- `ST_NESTED`: between the bottom and the deepest frame.
- `ST_DEEP`: frame equals `2**TAGW-1`.

Its transitions are:
- Call-in: `ST_TOP` to `ST_NESTED`, or directly to `ST_DEEP` when the depth limit is 1.
- Deeper: `ST_NESTED` to `ST_DEEP` when the new frame reaches the limit.
- Return-out: `ST_NESTED` or `ST_DEEP` to `ST_TOP` when the new frame is 0.
- Step-back: `ST_DEEP` to `ST_NESTED`.
- Stay: a call or return that does not cross a boundary keeps the state.
- Refused: a return in `ST_TOP`, a call in `ST_DEEP`, or both strobes in one cycle. The frame does not change.

Top module: `belt_store`

## Requirements
- R1: After reset the frame is 0 and every read port reports invalid with data 0.
- R2: A single accepted drop becomes position 0, and each older entry of the same frame moves one position further away.
- R3: When both drop inputs are valid, the value on drop 1 becomes position 0 and the value on drop 0 becomes position 1. A lone valid drop on either input becomes position 0.
- R4: Once more than LEN values have been dropped, the oldest are lost. Position LEN-1 holds the LEN-th newest value.
- R5: A read of a position at or beyond the number of live entries in the current frame reports invalid with data 0.
- R6: An accepted call makes the belt appear empty. Values dropped in the call cycle belong to the callee, with the newest at position 0.
- R7: An accepted return makes the caller's surviving entries visible again at their former positions. Values dropped in the return cycle are stacked on top of them.
- R8: Caller entries overwritten by the callee's drops are gone after the return, and the positions count only the survivors.
- R9: A return in `ST_TOP` is ignored: frame and contents are unchanged.
- R10: A call in `ST_DEEP` is ignored. Drops in that cycle join the current frame.
- R11: A call and a return in the same cycle leave the frame unchanged. Drops in that cycle join the current frame.
- R12: Entries left behind by an earlier callee are invisible to a later callee at the same depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| drop0_vld | input | 1 | Drop input 0 carries a result |
| drop0_val | input | W | Result on drop input 0 |
| drop1_vld | input | 1 | Drop input 1 carries a result |
| drop1_val | input | W | Result on drop input 1 (newer when both valid) |
| call_req | input | 1 | Call strobe |
| ret_req | input | 1 | Return strobe |
| rd0_pos | input | PW | Belt position for read port 0 |
| rd1_pos | input | PW | Belt position for read port 1 |
| rd0_val | output | W | Operand at rd0_pos, 0 when invalid |
| rd0_ok | output | 1 | rd0_pos names a live entry of the current frame |
| rd1_val | output | W | Operand at rd1_pos, 0 when invalid |
| rd1_ok | output | 1 | rd1_pos names a live entry of the current frame |

## Verification
A call and an argument drop can land in the same cycle. The purge of slots that carry the new frame number then meets the write of the arguments, which carry that same number, possibly on the same slot. This collision is forced by returning from a callee that left entries right at the head, then calling again with two arguments. A full two-port sweep of all positions afterwards must show exactly the two arguments and nothing else. The same sweep is repeated after every cycle of a pseudo-random run that mixes single and double drops with calls and returns. Each result is judged against a shift-list model of the belt kept in the bench.

// File: rtl/belt_pkg.sv
`timescale 1ns/1ps
package belt_pkg;

    // Call-depth controller states
    typedef enum logic [1:0] {
        ST_TOP    = 2'd0,
        ST_NESTED = 2'd1,
        ST_DEEP   = 2'd2
    } depth_state_e;

    // Frame event decoded from the strobes
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_CALL = 2'd1,
        EV_RET  = 2'd2,
        EV_BOTH = 2'd3
    } frame_evt_e;

endpackage

// File: rtl/belt_frame_ctl.sv
`timescale 1ns/1ps
module belt_frame_ctl
    import belt_pkg::*;
#(
    parameter int TAGW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_i,
    input  logic            ret_i,
    output logic [TAGW-1:0] frame_o,
    output logic [TAGW-1:0] drop_tag_o,
    output logic            call_ok_o,
    output logic            ret_ok_o,
    output depth_state_e    state_o
);
    localparam logic [TAGW-1:0] MAX_FRAME = {TAGW{1'b1}};
    localparam logic [TAGW-1:0] ONE       = TAGW'(1);

    depth_state_e    state_q, state_d;
    logic [TAGW-1:0] frame_q, frame_d;
    frame_evt_e      evt;

    always_comb begin
        unique case ({call_i, ret_i})
            2'b10:   evt = EV_CALL;
            2'b01:   evt = EV_RET;
            2'b11:   evt = EV_BOTH;
            default: evt = EV_NONE;
        endcase
    end

    // next-state and next-frame
    always_comb begin
        state_d = state_q;
        frame_d = frame_q;
        unique case (state_q)
            ST_TOP: begin
                if (evt == EV_CALL) begin
                    frame_d = frame_q + ONE;
                    state_d = (frame_d == MAX_FRAME) ? ST_DEEP : ST_NESTED;
                end
            end
            ST_NESTED: begin
                if (evt == EV_CALL) begin
                    frame_d = frame_q + ONE;
                    state_d = (frame_d == MAX_FRAME) ? ST_DEEP : ST_NESTED;
                end else if (evt == EV_RET) begin
                    frame_d = frame_q - ONE;
                    state_d = (frame_d == '0) ? ST_TOP : ST_NESTED;
                end
            end
            ST_DEEP: begin
                if (evt == EV_RET) begin
                    frame_d = frame_q - ONE;
                    state_d = (frame_d == '0) ? ST_TOP : ST_NESTED;
                end
            end
            default: begin
                state_d = ST_TOP;
                frame_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_TOP;
            frame_q <= '0;
        end else begin
            state_q <= state_d;
            frame_q <= frame_d;
        end
    end

    // outputs
    always_comb begin
        call_ok_o  = (evt == EV_CALL) && (state_q != ST_DEEP);
        ret_ok_o   = (evt == EV_RET)  && (state_q != ST_TOP);
        drop_tag_o = frame_d;
        frame_o    = frame_q;
        state_o    = state_q;
    end

    a_r1_top_is_frame_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TOP) |-> (frame_q == '0));
    a_r6_call_raises_frame: assert property (@(posedge clk) disable iff (!rst_n)
        call_ok_o |=> (frame_q == $past(frame_q) + ONE));
    a_r7_ret_lowers_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ok_o |=> (frame_q == $past(frame_q) - ONE));
    a_r9_top_ret_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TOP && evt == EV_RET) |=> $stable(frame_q));
    a_r10_deep_call_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEEP && evt == EV_CALL) |=> $stable(frame_q));
    a_r11_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == EV_BOTH) |=> $stable(frame_q));
endmodule

// File: rtl/belt_slots.sv
`timescale 1ns/1ps
module belt_slots #(
    parameter int LEN  = 8,
    parameter int W    = 32,
    parameter int TAGW = 3,
    localparam int PW  = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            d0_vld,
    input  logic [W-1:0]    d0_val,
    input  logic            d1_vld,
    input  logic [W-1:0]    d1_val,
    input  logic [TAGW-1:0] drop_tag,
    input  logic            purge,
    output logic [PW-1:0]   head_o,
    output logic [W-1:0]    data_o [LEN],
    output logic [TAGW-1:0] tag_o  [LEN],
    output logic            vld_o  [LEN]
);
    logic [PW-1:0]   hd_q;
    logic [W-1:0]    data_q [LEN];
    logic [TAGW-1:0] tag_q  [LEN];
    logic            vld_q  [LEN];
    logic [1:0]      n_drop;
    logic [PW-1:0]   slot_a, slot_b;
    logic [W-1:0]    first_val;

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] h, input int k);
        int s;
        s = int'(h) + k;
        if (s >= LEN) s = s - LEN;
        return PW'(s);
    endfunction

    assign n_drop    = {1'b0, d0_vld} + {1'b0, d1_vld};
    assign first_val = d0_vld ? d0_val : d1_val;
    assign slot_a    = hd_q;
    assign slot_b    = adv(hd_q, 1);

    always_ff @(posedge clk) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= adv(hd_q, int'(n_drop));
    end

    for (genvar s = 0; s < LEN; s++) begin : g_slot
        localparam logic [PW-1:0] SID = PW'(s);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s]  <= 1'b0;
                tag_q[s]  <= '0;
                data_q[s] <= '0;
            end else begin
                if (purge && tag_q[s] == drop_tag) vld_q[s] <= 1'b0;
                if (n_drop != 2'd0 && slot_a == SID) begin
                    vld_q[s]  <= 1'b1;
                    tag_q[s]  <= drop_tag;
                    data_q[s] <= first_val;
                end
                if (n_drop == 2'd2 && slot_b == SID) begin
                    vld_q[s]  <= 1'b1;
                    tag_q[s]  <= drop_tag;
                    data_q[s] <= d1_val;
                end
            end
        end
        assign data_o[s] = data_q[s];
        assign tag_o[s]  = tag_q[s];
        assign vld_o[s]  = vld_q[s];
    end

    assign head_o = hd_q;

    a_r3_pair_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_vld && d1_vld && LEN > 1) |=>
            (vld_q[$past(slot_b)] && data_q[$past(slot_b)] == $past(d1_val)
             && tag_q[$past(slot_b)] == $past(drop_tag)));
    a_r2_single_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_vld && !d1_vld) |=>
            (vld_q[$past(slot_a)] && data_q[$past(slot_a)] == $past(d0_val)));
endmodule

// File: rtl/belt_view.sv
`timescale 1ns/1ps
module belt_view #(
    parameter int LEN  = 8,
    parameter int W    = 32,
    parameter int TAGW = 3,
    localparam int PW  = (LEN > 1) ? $clog2(LEN) : 1,
    localparam int CW  = $clog2(LEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   head_i,
    input  logic [W-1:0]    data_i [LEN],
    input  logic [TAGW-1:0] tag_i  [LEN],
    input  logic            vld_i  [LEN],
    input  logic [TAGW-1:0] frame_i,
    input  logic [PW-1:0]   pos_i,
    output logic [W-1:0]    val_o,
    output logic            ok_o
);
    logic [PW-1:0] idx   [LEN];
    logic          match [LEN];
    logic [CW-1:0] live_cnt;

    // age a is the a-th slot behind the head
    for (genvar a = 0; a < LEN; a++) begin : g_age
        always_comb begin
            int t;
            t = int'(head_i) - 1 - a;
            if (t < 0) t = t + LEN;
            idx[a] = PW'(t);
        end
        assign match[a] = vld_i[idx[a]] && (tag_i[idx[a]] == frame_i);
    end

    // rank the frame's entries by age and pick the requested one
    always_comb begin
        int rank;
        rank  = 0;
        val_o = '0;
        ok_o  = 1'b0;
        for (int a = 0; a < LEN; a++) begin
            if (match[a]) begin
                if (rank == int'(pos_i)) begin
                    val_o = data_i[idx[a]];
                    ok_o  = 1'b1;
                end
                rank = rank + 1;
            end
        end
    end

    always_comb begin
        live_cnt = '0;
        for (int s = 0; s < LEN; s++)
            if (vld_i[s] && tag_i[s] == frame_i) live_cnt = live_cnt + CW'(1);
    end

    a_r5_ok_within_count: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> (int'(pos_i) < int'(live_cnt)));
    a_r5_empty_never_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == '0) |-> (!ok_o && val_o == '0));
endmodule

// File: rtl/belt_store.sv
`timescale 1ns/1ps
module belt_store
    import belt_pkg::*;
#(
    parameter int LEN  = 8,
    parameter int W    = 32,
    parameter int TAGW = 3,
    localparam int PW  = (LEN > 1) ? $clog2(LEN) : 1,
    localparam int NRD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drop0_vld,
    input  logic [W-1:0]  drop0_val,
    input  logic          drop1_vld,
    input  logic [W-1:0]  drop1_val,
    input  logic          call_req,
    input  logic          ret_req,
    input  logic [PW-1:0] rd0_pos,
    input  logic [PW-1:0] rd1_pos,
    output logic [W-1:0]  rd0_val,
    output logic          rd0_ok,
    output logic [W-1:0]  rd1_val,
    output logic          rd1_ok
);
    logic [TAGW-1:0] frame, drop_tag;
    logic            call_ok, ret_ok;
    depth_state_e    dstate;
    logic [PW-1:0]   head;
    logic [W-1:0]    s_data [LEN];
    logic [TAGW-1:0] s_tag  [LEN];
    logic            s_vld  [LEN];
    logic [PW-1:0]   rpos [NRD];
    logic [W-1:0]    rval [NRD];
    logic            rok  [NRD];

    belt_frame_ctl #(.TAGW(TAGW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .call_i     (call_req),
        .ret_i      (ret_req),
        .frame_o    (frame),
        .drop_tag_o (drop_tag),
        .call_ok_o  (call_ok),
        .ret_ok_o   (ret_ok),
        .state_o    (dstate)
    );

    belt_slots #(.LEN(LEN), .W(W), .TAGW(TAGW)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .d0_vld   (drop0_vld),
        .d0_val   (drop0_val),
        .d1_vld   (drop1_vld),
        .d1_val   (drop1_val),
        .drop_tag (drop_tag),
        .purge    (call_ok),
        .head_o   (head),
        .data_o   (s_data),
        .tag_o    (s_tag),
        .vld_o    (s_vld)
    );

    assign rpos[0] = rd0_pos;
    assign rpos[1] = rd1_pos;

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        belt_view #(.LEN(LEN), .W(W), .TAGW(TAGW)) u_view (
            .clk     (clk),
            .rst_n   (rst_n),
            .head_i  (head),
            .data_i  (s_data),
            .tag_i   (s_tag),
            .vld_i   (s_vld),
            .frame_i (frame),
            .pos_i   (rpos[r]),
            .val_o   (rval[r]),
            .ok_o    (rok[r])
        );
    end

    assign rd0_val = rval[0];
    assign rd0_ok  = rok[0];
    assign rd1_val = rval[1];
    assign rd1_ok  = rok[1];

    a_r6_callee_sees_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (call_ok && !drop0_vld && !drop1_vld) |=> (!rd0_ok && !rd1_ok));
    a_r10_deep_state_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        (dstate == ST_DEEP) |-> (frame == {TAGW{1'b1}} && !ret_ok || ret_req));
endmodule

// File: tb/belt_store_tb.sv
`timescale 1ns/1ps
module belt_store_tb;
    localparam int LEN  = 8;
    localparam int W    = 16;
    localparam int TAGW = 2;
    localparam int PW   = 3;
    localparam int MAXF = (1 << TAGW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drop0_vld = 0, drop1_vld = 0, call_req = 0, ret_req = 0;
    logic [W-1:0] drop0_val = '0, drop1_val = '0;
    logic [PW-1:0] rd0_pos = '0, rd1_pos = '0;
    logic [W-1:0] rd0_val, rd1_val;
    logic rd0_ok, rd1_ok;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // reference: shift list, index 0 newest
    logic [W-1:0] m_dat [LEN];
    int           m_tag [LEN];
    bit           m_vld [LEN];
    int           m_frame = 0;

    always #2 clk = ~clk;

    belt_store #(.LEN(LEN), .W(W), .TAGW(TAGW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .drop0_vld(drop0_vld), .drop0_val(drop0_val),
        .drop1_vld(drop1_vld), .drop1_val(drop1_val),
        .call_req(call_req), .ret_req(ret_req),
        .rd0_pos(rd0_pos), .rd1_pos(rd1_pos),
        .rd0_val(rd0_val), .rd0_ok(rd0_ok),
        .rd1_val(rd1_val), .rd1_ok(rd1_ok)
    );

    task automatic check(input string req, input int pos, input int port,
                         input logic ok_a, input logic [W-1:0] v_a,
                         input logic ok_e, input logic [W-1:0] v_e);
        n_chk++;
        if (ok_a !== ok_e || v_a !== v_e) begin
            n_err++;
            $display("FAIL %s port%0d pos%0d: actual ok=%0b val=%h expected ok=%0b val=%h",
                     req, port, pos, ok_a, v_a, ok_e, v_e);
        end
    endtask

    task automatic model_get(input int p, output logic ok, output logic [W-1:0] v);
        int rank = 0;
        ok = 0; v = '0;
        for (int a = 0; a < LEN; a++) begin
            if (m_vld[a] && m_tag[a] == m_frame) begin
                if (rank == p) begin ok = 1; v = m_dat[a]; end
                rank++;
            end
        end
    endtask

    task automatic model_push(input logic [W-1:0] v, input int tg);
        for (int a = LEN - 1; a > 0; a--) begin
            m_dat[a] = m_dat[a-1]; m_tag[a] = m_tag[a-1]; m_vld[a] = m_vld[a-1];
        end
        m_dat[0] = v; m_tag[0] = tg; m_vld[0] = 1;
    endtask

    task automatic sweep(input string req);
        for (int p = 0; p < LEN; p++) begin
            logic ok0, ok1;
            logic [W-1:0] v0, v1;
            rd0_pos = PW'(p);
            rd1_pos = PW'(LEN - 1 - p);
            #0.2;
            model_get(p, ok0, v0);
            model_get(LEN - 1 - p, ok1, v1);
            // positions past the live count fall under R5
            check(ok0 ? req : {req, "/R5"}, p, 0, rd0_ok, rd0_val, ok0, v0);
            check(ok1 ? req : {req, "/R5"}, LEN - 1 - p, 1, rd1_ok, rd1_val, ok1, v1);
        end
    endtask

    task automatic step(input logic v0, input logic [W-1:0] d0,
                        input logic v1, input logic [W-1:0] d1,
                        input logic c, input logic r, input string req);
        int nf;
        @(negedge clk);
        drop0_vld = v0; drop0_val = d0; drop1_vld = v1; drop1_val = d1;
        call_req = c; ret_req = r;
        @(posedge clk);
        nf = m_frame;
        if (c && !r && m_frame < MAXF) nf = m_frame + 1;
        else if (r && !c && m_frame > 0) nf = m_frame - 1;
        if (nf == m_frame + 1)
            for (int a = 0; a < LEN; a++) if (m_tag[a] == nf) m_vld[a] = 0;
        if (v0) model_push(d0, nf);
        if (v1) model_push(d1, nf);
        m_frame = nf;
        #0.1;
        drop0_vld = 0; drop1_vld = 0; call_req = 0; ret_req = 0;
        sweep(req);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int a = 0; a < LEN; a++) begin m_dat[a] = '0; m_tag[a] = 0; m_vld[a] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #0.5;
        sweep("R1");

        // R2 single drops, R3 lone drop1
        step(1, 16'h0A01, 0, '0, 0, 0, "R2");
        step(1, 16'h0A02, 0, '0, 0, 0, "R2");
        step(0, '0, 1, 16'h0B03, 0, 0, "R3");
        // R3 pair
        step(1, 16'h0C04, 1, 16'h0C05, 0, 0, "R3");
        // R4 wrap past LEN
        for (int i = 0; i < 6; i++) step(1, W'(16'h0D00 + i), 0, '0, 0, 0, "R4");
        step(1, 16'h0E01, 1, 16'h0E02, 0, 0, "R4");
        // R9 return at top level
        step(0, '0, 0, '0, 0, 1, "R9");
        // R6 call with two arguments
        step(1, 16'h1001, 1, 16'h1002, 1, 0, "R6");
        // R8 callee overwrites part of the caller
        for (int i = 0; i < 3; i++) step(1, W'(16'h1100 + i), 0, '0, 0, 0, "R8");
        // R7 return with one result
        step(1, 16'h1201, 0, '0, 0, 1, "R7");
        // R12 new callee sees no stale entries
        step(0, '0, 0, '0, 1, 0, "R12");
        step(1, 16'h1301, 0, '0, 0, 0, "R12");
        step(0, '0, 0, '0, 0, 1, "R7");
        // R12 purge collides with argument write at the head
        step(1, 16'h1401, 1, 16'h1402, 1, 0, "R12");
        step(0, '0, 0, '0, 0, 1, "R7");
        // R10 nest to the limit then one more call
        step(0, '0, 0, '0, 1, 0, "R6");
        step(1, 16'h1501, 0, '0, 1, 0, "R6");
        step(1, 16'h1502, 0, '0, 1, 0, "R6");
        step(1, 16'h1601, 0, '0, 1, 0, "R10");
        // R11 call and return together
        step(1, 16'h1701, 0, '0, 1, 1, "R11");
        for (int i = 0; i < MAXF; i++) step(0, '0, 0, '0, 0, 1, "R7");
        step(0, '0, 1, 16'h1801, 1, 1, "R11");

        // pseudo-random mix
        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            logic c, r;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            c = (lf[6:4] == 3'b000);
            r = (lf[9:7] == 3'b000);
            step(lf[0], {lf[15:8], lf[7:0] ^ 8'h5A}, lf[1], W'(i), c, r, "R2");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule